// File: doc/BRIEF.md
# Flash Read Area Pointer Decoder

This block sits on the device side of a small-page NAND-style flash read path. It watches bus cycles on an 8-bit I/O bus. A qualified write strobe marks each bus cycle. The command-latch and address-latch inputs mark each cycle as a command byte or an address byte. The block decodes three read commands. Each command selects one area of the page: the first half of the main area, the second half of the main area, or the spare area. The block keeps that choice as a pointer, collects the address bytes that follow, and then hands a resolved start column, row address and area to a downstream page-read sequencer. It announces that hand-off with a one-cycle start-read strobe.

The pointer for the first main half and for the spare area is sticky. Later read operations may send only address bytes and still use the last selected area. The pointer for the second main half lasts for one operation only. When the sequencer reports that operation finished, the pointer falls back to the first half. The number of address bytes is a build parameter, either three or four. The first address byte is always the column; the remaining bytes form the row, least significant byte first. In the spare area only the low column bits are used, and how many depends on the bus-width parameter.

Top module: `flash_read_ptr`

## Requirements
- R1: After reset, `area` is 0 (area encoding: 0 = main first half, 1 = main second half, 2 = spare) and `start_read` is low.
- R2: A command cycle (`wr_stb` and `cmd_latch` high) carrying 0x00, 0x01 or 0x50 sets `area` to 0, 1 or 2 respectively on the next clock. It also restarts address collection at the column byte.
- R3: An address cycle (`wr_stb` and `addr_latch` high, `cmd_latch` low) is counted as one address byte. After `ADDR_CYCLES` bytes (3 or 4), `start_read` is high for exactly one cycle, the clock after the last byte.
- R4: While `start_read` is high, `start_row` equals the address bytes after the first, with the second byte in bits 7:0, the third in bits 15:8, and so on. `start_area` equals `area`.
- R5: In areas 0 and 1, `start_col` is {area==1, column byte}.
- R6: In area 2, `start_col` keeps only the column byte's low 4 bits (`BUS16`=0) or low 3 bits (`BUS16`=1); all higher bits read as zero.
- R7: Areas 0 and 2 persist: a later address-only sequence starts a read in the same area, and a `read_done` pulse leaves `area` unchanged.
- R8: Area 1 is one-shot. After a read has started in area 1, a `read_done` pulse returns `area` to 0. A `read_done` before any read has started in area 1 leaves `area` at 1.
- R9: Any other command byte leaves `area` unchanged and discards a partly collected address, so no `start_read` comes from the bytes already sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle qualifier for a bus write cycle |
| cmd_latch | input | 1 | Marks the bus cycle as a command byte |
| addr_latch | input | 1 | Marks the bus cycle as an address byte |
| io_in | input | 8 | I/O bus byte |
| read_done | input | 1 | Pulse from the sequencer when a read operation completes |
| area | output | 2 | Current area pointer |
| start_read | output | 1 | One-cycle strobe to start a page read |
| start_area | output | 2 | Area of the started read |
| start_col | output | 9 | Resolved start column |
| start_row | output | 8*(ADDR_CYCLES-1) | Row address |

## Verification
The hardest situation to reach is the one-shot pointer at its edges. A `read_done` pulse can arrive either before or after a second-half read has actually started, and only the second case may release the pointer. The stimulus selects area 1 and pulses `read_done` with no address yet sent, confirming the pointer holds. It then completes an address sequence, pulses `read_done` again and issues an address-only read, confirming that this read starts in area 0. A command that aborts a half-collected address is followed by a full address sequence. The scoreboard then expects exactly one start, carrying the later bytes.

// File: rtl/flash_read_ptr.sv
module flash_read_ptr #(
  parameter int ADDR_CYCLES = 4,
  parameter bit BUS16 = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_stb,
  input  logic                           cmd_latch,
  input  logic                           addr_latch,
  input  logic [7:0]                     io_in,
  input  logic                           read_done,
  output logic [1:0]                     area,
  output logic                           start_read,
  output logic [1:0]                     start_area,
  output logic [8:0]                     start_col,
  output logic [8*(ADDR_CYCLES-1)-1:0]   start_row
);
  localparam int ROW_W = 8*(ADDR_CYCLES-1);
  localparam logic [7:0] SP_MASK = BUS16 ? 8'h07 : 8'h0F;
  localparam logic [1:0] AR_MAIN0 = 2'd0, AR_MAIN1 = 2'd1, AR_SPARE = 2'd2;

  logic [1:0]       area_q;
  logic [1:0]       cnt_q;
  logic [7:0]       col_q;
  logic [ROW_W-1:0] row_q, row_nx;
  logic             b_pend_q;

  wire cmd_cyc  = wr_stb & cmd_latch;
  wire addr_cyc = wr_stb & addr_latch & ~cmd_latch;
  wire last_byte = addr_cyc && (int'(cnt_q) == ADDR_CYCLES-1);
  wire known = (io_in == 8'h00) || (io_in == 8'h01) || (io_in == 8'h50);

  always_comb begin
    row_nx = row_q;
    if (addr_cyc && cnt_q != 2'd0)
      row_nx[8*(int'(cnt_q)-1) +: 8] = io_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_q     <= AR_MAIN0;
      cnt_q      <= '0;
      col_q      <= '0;
      row_q      <= '0;
      b_pend_q   <= 1'b0;
      start_read <= 1'b0;
      start_area <= AR_MAIN0;
      start_col  <= '0;
      start_row  <= '0;
    end else begin
      start_read <= 1'b0;
      if (cmd_cyc) begin
        cnt_q <= '0;
        if (known) begin
          b_pend_q <= 1'b0;
          case (io_in)
            8'h01:   area_q <= AR_MAIN1;
            8'h50:   area_q <= AR_SPARE;
            default: area_q <= AR_MAIN0;
          endcase
        end else if (read_done && b_pend_q) begin
          area_q   <= AR_MAIN0;
          b_pend_q <= 1'b0;
        end
      end else begin
        if (read_done && b_pend_q) begin
          area_q   <= AR_MAIN0;
          b_pend_q <= 1'b0;
        end
        if (addr_cyc) begin
          row_q <= row_nx;
          if (cnt_q == 2'd0) col_q <= io_in;
          if (last_byte) begin
            cnt_q      <= '0;
            start_read <= 1'b1;
            start_area <= area_q;
            start_row  <= row_nx;
            start_col  <= (area_q == AR_SPARE) ? {1'b0, col_q & SP_MASK}
                                               : {area_q == AR_MAIN1, col_q};
            if (area_q == AR_MAIN1) b_pend_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
      end
    end
  end

  assign area = area_q;
endmodule

module flash_read_ptr_chk #(
  parameter bit BUS16 = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       cmd_latch,
  input logic       addr_latch,
  input logic [7:0] io_in,
  input logic       read_done,
  input logic [1:0] area,
  input logic       start_read,
  input logic [1:0] start_area,
  input logic [8:0] start_col,
  input logic       b_pend_q
);
  wire cmd_cyc = wr_stb & cmd_latch;
  wire unknown = cmd_cyc && !(io_in == 8'h00 || io_in == 8'h01 || io_in == 8'h50);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_read |=> !start_read);
  // R4
  start_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_read |-> start_area == area);
  // R6
  spare_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_read && start_area == 2'd2) |->
      (BUS16 ? start_col[8:3] == 6'd0 : start_col[8:4] == 5'd0));
  // R9
  unknown_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unknown && !read_done) |=> $stable(area));
  // R8
  oneshot_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && b_pend_q && !cmd_cyc) |=> area == 2'd0);
  // R2
  spare_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && io_in == 8'h50) |=> area == 2'd2);
  // R7
  persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cyc && area != 2'd1) |=> $stable(area));
endmodule

bind flash_read_ptr flash_read_ptr_chk #(.BUS16(BUS16)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_latch(cmd_latch),
  .addr_latch(addr_latch), .io_in(io_in), .read_done(read_done),
  .area(area), .start_read(start_read), .start_area(start_area),
  .start_col(start_col), .b_pend_q(b_pend_q)
);

// File: tb/flash_read_ptr_bench.sv
module flash_read_ptr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 1'b0, cmd_latch = 1'b0, addr_latch = 1'b0, read_done = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic [1:0] area, start_area;
  logic start_read;
  logic [8:0] start_col;
  logic [23:0] start_row;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [34:0] exp_q[$];

  always #5 clk = ~clk;

  flash_read_ptr #(.ADDR_CYCLES(4), .BUS16(1'b0)) u_flash_read_ptr (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .io_in(io_in), .read_done(read_done),
    .area(area), .start_read(start_read), .start_area(start_area),
    .start_col(start_col), .start_row(start_row));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R3 R4 R5 R6
  always @(negedge clk) if (rst_n && start_read) begin
    if (exp_q.size() == 0) chk("R3/R9 unexpected start", 1, 0);
    else begin
      logic [34:0] e;
      e = exp_q.pop_front();
      chk("R3/R4/R5/R6 start item", {start_area, start_col, start_row}, e);
    end
  end

  task automatic bus(input bit c, input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; cmd_latch = c; addr_latch = a; io_in = d;
    @(negedge clk);
    wr_stb = 1'b0; cmd_latch = 1'b0; addr_latch = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); read_done = 1'b1;
    @(negedge clk); read_done = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ar, input logic [7:0] col, input logic [23:0] row);
    logic [8:0] ec;
    ec = (ar == 2'd2) ? {5'd0, col[3:0]} : {ar == 2'd1, col};
    exp_q.push_back({ar, ec, row});
    bus(0, 1, col); bus(0, 1, row[7:0]); bus(0, 1, row[15:8]); bus(0, 1, row[23:16]);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 area", area, 0);
    chk("R1 start_read", start_read, 0);
    rst_n = 1'b1;
    bus(1, 0, 8'h00); chk("R2 cmd 00", area, 0);
    rd(2'd0, 8'hA5, 24'h123456);
    rd(2'd0, 8'h3C, 24'h0000FF);           // R7 address-only reuse
    bus(1, 0, 8'h50); chk("R2 cmd 50", area, 2);
    rd(2'd2, 8'hFF, 24'hABCDEF);           // R6 mask
    rd(2'd2, 8'h3A, 24'h010203);           // R7 spare persists
    done_pulse(); chk("R7 done keeps spare", area, 2);
    bus(1, 0, 8'h77); chk("R9 unknown keeps area", area, 2);
    bus(1, 0, 8'h01); chk("R2 cmd 01", area, 1);
    done_pulse(); chk("R8 early done keeps 1", area, 1);
    rd(2'd1, 8'h12, 24'h445566);           // R5 second half
    chk("R8 still 1 before done", area, 1);
    done_pulse(); chk("R8 return to 0", area, 0);
    rd(2'd0, 8'h80, 24'h778899);           // R8 next read in area 0
    bus(1, 0, 8'h00); bus(0, 1, 8'h11); bus(0, 1, 8'h22);
    bus(1, 0, 8'hFF); chk("R9 abort keeps area", area, 0);
    rd(2'd0, 8'h5A, 24'hC0FFEE);           // R9 only later bytes start
    bus(1, 0, 8'h50); bus(0, 1, 8'h09); bus(0, 1, 8'h01);
    bus(1, 0, 8'h00);                       // R2 restart collection
    rd(2'd0, 8'h44, 24'h332211);
    repeat (4) @(negedge clk);
    chk("R3 all starts seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); chk("watchdog", 1, 0); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule